// File: doc/BRIEF.md
# Two-Layer Window Compositor with Colour Keying

This block builds one 24-bit RGB output pixel per clock from two streams of layer pixels, already expanded to 32-bit ARGB, and a solid background colour. Each layer has an inclusive window rectangle, a default ARGB colour that stands in for frame data outside the window or while the layer is off, a constant alpha, an alpha-mode select and an optional RGB colour key. At every screen coordinate each layer picks its pixel or its default colour, applies keying and works out an effective alpha. The background is then covered by layer 1, and the result by layer 2.

All layer settings and the background colour are written into a shadow set through a small word-wide write port. The shadow set is copied to the active set either at once, or at the next vertical blanking. The pixel pipeline has a fixed latency, and the valid flag and coordinates travel with the pixel.

Top module: `layer_compositor`

## Requirements
- R1: A layer that is enabled shows its stream pixel when first column <= x <= last column and first line <= y <= last line, bounds inclusive. At any other coordinate it shows its default colour.
- R2: A layer whose enable bit is 0 shows its default ARGB colour at every coordinate, whatever its stream carries.
- R3: When a layer's key-enable bit is 1 and the RGB of its chosen pixel equals its key RGB, all four channels of that pixel become 0 before the alpha is computed. Pixel alpha is not part of the match.
- R4: With alpha mode 0, the effective alpha is the constant alpha. With alpha mode 1, it is (pixel_alpha*const_alpha+127)/255, integer division.
- R5: Each colour channel is blended as (a*top+(255-a)*below+127)/255. The order is fixed: layer 1 over the background, then layer 2 over that result.
- R6: A layer with effective alpha 0 leaves the colour beneath it unchanged. A disabled layer with opaque black default and constant alpha 0xFF in mode 0 turns the whole output black.
- R7: Writes with cfg_we go only to the shadow set and do not change the output until a reload. The layer is picked by cfg_layer (0 = layer 1, 1 = layer 2) and the field by cfg_field. Field 0 holds the first column in [15:0] and the last column in [31:16]. Field 1 holds the first line in [15:0] and the last line in [31:16]. Field 2 is the default ARGB, with alpha in [31:24]. Field 3 holds the key RGB in [23:0] and key enable in [24]. Field 4 holds the layer enable in [0], the alpha mode in [1] and the constant alpha in [15:8]. Field 5 is the background RGB in [23:0], and cfg_layer is ignored for it. Fields 6 and 7 are ignored.
- R8: A reload_now pulse copies the shadow set to the active set at that clock edge. reload_done is high for exactly the following cycle.
- R9: A reload_vblank pulse sets reload_pending. While pending is set and vblank is low, the active set is unchanged. At the first edge with vblank high the copy happens, reload_pending clears and reload_done pulses for one cycle.
- R10: out_valid, out_x, out_y and out_rgb appear exactly 3 clock edges after the matching pix_valid, pix_x, pix_y and stream pixels are sampled.
- R11: After reset the active and shadow sets are all zero. out_valid, reload_pending and reload_done are 0, and a valid pixel comes out black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Shadow write strobe |
| cfg_layer | input | 1 | Layer select for the write (0 = layer 1) |
| cfg_field | input | 3 | Field select for the write |
| cfg_wdata | input | 32 | Write data |
| reload_now | input | 1 | Request an immediate shadow-to-active copy |
| reload_vblank | input | 1 | Request a copy at the next vertical blanking |
| vblank | input | 1 | Vertical blanking indicator |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | CW | Screen column |
| pix_y | input | CW | Screen line |
| l1_pix | input | 32 | Layer 1 ARGB stream pixel |
| l2_pix | input | 32 | Layer 2 ARGB stream pixel |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | CW | Column of the output pixel |
| out_y | output | CW | Line of the output pixel |
| out_rgb | output | 24 | Composed RGB |
| reload_pending | output | 1 | Vertical-blanking reload waiting |
| reload_done | output | 1 | One-cycle pulse when a reload takes effect |

## Verification
The bench builds the block with CW = 4, so the screen is 16 by 16. With that size it can sweep every coordinate, both inside and outside each window, and hit every window edge on both axes, under three layer configurations. Those configurations cover the constant and product alpha modes, key hits mixed with near-misses, a vanishing top layer and an opaque black cover. The reload sequences check that the shadow set is isolated from the output, and that the pending flag and done pulse happen on the right cycles.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int NLAYER = 2;
  localparam int CRD_W  = 16;
  localparam int NCH    = 3;

  typedef struct packed {
    logic [CRD_W-1:0] x_lo;
    logic [CRD_W-1:0] x_hi;
    logic [CRD_W-1:0] y_lo;
    logic [CRD_W-1:0] y_hi;
    logic [31:0]      dflt;
    logic             key_en;
    logic [23:0]      key;
    logic             en;
    logic             amode;
    logic [7:0]       calpha;
  } layer_cfg_t;

  // (x*y + 127) / 255
  function automatic logic [7:0] mul_round(input logic [7:0] p, input logic [7:0] q);
    logic [16:0] s;
    s = 17'(p) * 17'(q) + 17'd127;
    return 8'(s / 17'd255);
  endfunction

  // (a*top + (255-a)*below + 127) / 255
  function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] t,
                                      input logic [7:0] b);
    logic [16:0] s;
    s = 17'(a) * 17'(t) + 17'(8'd255 - a) * 17'(b) + 17'd127;
    return 8'(s / 17'd255);
  endfunction
endpackage

// File: rtl/lc_shadow_regs.sv
module lc_shadow_regs
  import lc_pkg::*;
#(
  parameter int NL = NLAYER,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [LW-1:0]         cfg_layer,
  input  logic [2:0]            cfg_field,
  input  logic [31:0]           cfg_wdata,
  input  logic                  reload_now,
  input  logic                  reload_vblank,
  input  logic                  vblank,
  output layer_cfg_t [NL-1:0]   act_cfg,
  output logic [23:0]           act_bg,
  output logic                  reload_pending,
  output logic                  reload_done
);
  layer_cfg_t [NL-1:0] sh_cfg;
  logic [23:0]         sh_bg;
  logic                do_reload;

  assign do_reload = reload_now | (reload_pending & vblank);

  for (genvar i = 0; i < NL; i++) begin : g_layer
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_cfg[i] <= '0;
      end else if (cfg_we && cfg_layer == LW'(i)) begin
        case (cfg_field)
          3'd0: begin
            sh_cfg[i].x_lo <= cfg_wdata[15:0];
            sh_cfg[i].x_hi <= cfg_wdata[31:16];
          end
          3'd1: begin
            sh_cfg[i].y_lo <= cfg_wdata[15:0];
            sh_cfg[i].y_hi <= cfg_wdata[31:16];
          end
          3'd2: sh_cfg[i].dflt <= cfg_wdata;
          3'd3: begin
            sh_cfg[i].key    <= cfg_wdata[23:0];
            sh_cfg[i].key_en <= cfg_wdata[24];
          end
          3'd4: begin
            sh_cfg[i].en     <= cfg_wdata[0];
            sh_cfg[i].amode  <= cfg_wdata[1];
            sh_cfg[i].calpha <= cfg_wdata[15:8];
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)         act_cfg[i] <= '0;
      else if (do_reload) act_cfg[i] <= sh_cfg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          sh_bg <= '0;
    else if (cfg_we && cfg_field == 3'd5) sh_bg <= cfg_wdata[23:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_bg         <= '0;
      reload_pending <= 1'b0;
      reload_done    <= 1'b0;
    end else begin
      if (do_reload) act_bg <= sh_bg;
      if (do_reload)          reload_pending <= 1'b0;
      else if (reload_vblank) reload_pending <= 1'b1;
      reload_done <= do_reload;
    end
  end

  assert_now_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_now |=> reload_done);
  assert_vblank_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pending && vblank) |=> (reload_done && !reload_pending));
  assert_pending_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pending && !vblank && !reload_now) |=> reload_pending);
  assert_active_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_now && !(reload_pending && vblank)) |=> ($stable(act_cfg) && $stable(act_bg)));
endmodule

// File: rtl/lc_layer_stage.sv
module lc_layer_stage
  import lc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  layer_cfg_t       cfg,
  input  logic [CRD_W-1:0] x,
  input  logic [CRD_W-1:0] y,
  input  logic [31:0]      pix,
  output logic [31:0]      q_argb,
  output logic [7:0]       q_alpha
);
  logic        in_win;
  logic        use_pix;
  logic [31:0] chosen;
  logic        key_hit;
  logic [31:0] keyed;
  logic [7:0]  alpha;

  assign in_win  = (x >= cfg.x_lo) && (x <= cfg.x_hi) && (y >= cfg.y_lo) && (y <= cfg.y_hi);
  assign use_pix = cfg.en && in_win;
  assign chosen  = use_pix ? pix : cfg.dflt;
  assign key_hit = cfg.key_en && (chosen[23:0] == cfg.key);
  assign keyed   = key_hit ? 32'h0 : chosen;
  assign alpha   = cfg.amode ? mul_round(keyed[31:24], cfg.calpha) : cfg.calpha;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_argb  <= '0;
      q_alpha <= '0;
    end else begin
      q_argb  <= keyed;
      q_alpha <= alpha;
    end
  end

  assert_key_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (q_argb == 32'h0));
  assert_off_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && !cfg.key_en) |=> (q_argb == $past(cfg.dflt)));
  assert_const_alpha_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.amode |=> (q_alpha == $past(cfg.calpha)));
endmodule

// File: rtl/lc_mix_stage.sv
module lc_mix_stage
  import lc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     alpha,
  input  logic [NCH*8-1:0] top,
  input  logic [NCH*8-1:0] below,
  output logic [NCH*8-1:0] q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) q[c*8 +: 8] <= '0;
      else        q[c*8 +: 8] <= mix8(alpha, top[c*8 +: 8], below[c*8 +: 8]);
    end
  end

  assert_clear_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alpha == 8'd0) |=> (q == $past(below)));
  assert_opaque_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alpha == 8'd255) |=> (q == $past(top)));
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import lc_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_layer,
  input  logic [2:0]    cfg_field,
  input  logic [31:0]   cfg_wdata,
  input  logic          reload_now,
  input  logic          reload_vblank,
  input  logic          vblank,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [31:0]   l1_pix,
  input  logic [31:0]   l2_pix,
  output logic          out_valid,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y,
  output logic [23:0]   out_rgb,
  output logic          reload_pending,
  output logic          reload_done
);
  localparam int LAT = 3;

  layer_cfg_t [NLAYER-1:0] act_cfg;
  logic [23:0]             act_bg;
  logic [31:0]             lpix     [NLAYER];
  logic [31:0]             s1_argb  [NLAYER];
  logic [7:0]              s1_alpha [NLAYER];
  logic [23:0]             bg_s1;
  logic [23:0]             c1_s2;
  logic [23:0]             l2_s2;
  logic [7:0]              a2_s2;
  logic [LAT-1:0]          vpipe;
  logic [CW-1:0]           xpipe [LAT];
  logic [CW-1:0]           ypipe [LAT];

  lc_shadow_regs #(.NL(NLAYER)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_layer(cfg_layer),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .reload_now(reload_now),
    .reload_vblank(reload_vblank), .vblank(vblank), .act_cfg(act_cfg),
    .act_bg(act_bg), .reload_pending(reload_pending), .reload_done(reload_done)
  );

  assign lpix[0] = l1_pix;
  assign lpix[1] = l2_pix;

  for (genvar i = 0; i < NLAYER; i++) begin : g_lyr
    lc_layer_stage u_stage (
      .clk(clk), .rst_n(rst_n), .cfg(act_cfg[i]),
      .x(CRD_W'(pix_x)), .y(CRD_W'(pix_y)), .pix(lpix[i]),
      .q_argb(s1_argb[i]), .q_alpha(s1_alpha[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_s1 <= '0;
      l2_s2 <= '0;
      a2_s2 <= '0;
    end else begin
      bg_s1 <= act_bg;
      l2_s2 <= s1_argb[1][23:0];
      a2_s2 <= s1_alpha[1];
    end
  end

  lc_mix_stage u_mix_lo (
    .clk(clk), .rst_n(rst_n), .alpha(s1_alpha[0]),
    .top(s1_argb[0][23:0]), .below(bg_s1), .q(c1_s2)
  );

  lc_mix_stage u_mix_hi (
    .clk(clk), .rst_n(rst_n), .alpha(a2_s2),
    .top(l2_s2), .below(c1_s2), .q(out_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
      for (int k = 0; k < LAT; k++) begin
        xpipe[k] <= '0;
        ypipe[k] <= '0;
      end
    end else begin
      vpipe <= {vpipe[LAT-2:0], pix_valid};
      xpipe[0] <= pix_x;
      ypipe[0] <= pix_y;
      for (int k = 1; k < LAT; k++) begin
        xpipe[k] <= xpipe[k-1];
        ypipe[k] <= ypipe[k-1];
      end
    end
  end

  assign out_valid = vpipe[LAT-1];
  assign out_x     = xpipe[LAT-1];
  assign out_y     = ypipe[LAT-1];

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                         since_rst <= '0;
    else if (since_rst != 2'(LAT))      since_rst <= since_rst + 2'd1;
  end

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'(LAT)) |-> (out_valid == $past(pix_valid, LAT)));
  assert_coord_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'(LAT)) |-> (out_x == $past(pix_x, LAT) && out_y == $past(pix_y, LAT)));
endmodule

// File: tb/layer_compositor_test.sv
module layer_compositor_test;
  localparam int CW = 4;
  localparam int SIDE = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_layer = 0;
  logic [2:0] cfg_field = 0;
  logic [31:0] cfg_wdata = 0;
  logic reload_now = 0, reload_vblank = 0, vblank = 0;
  logic pix_valid = 0;
  logic [CW-1:0] pix_x = 0, pix_y = 0;
  logic [31:0] l1_pix = 0, l2_pix = 0;
  logic out_valid;
  logic [CW-1:0] out_x, out_y;
  logic [23:0] out_rgb;
  logic reload_pending, reload_done;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench-side model: shadow and active words per layer and field
  logic [31:0] sw [2][5];
  logic [31:0] aw [2][5];
  logic [23:0] sbg, abg;

  always #2.5 clk = ~clk;

  layer_compositor #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_layer(cfg_layer),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .reload_now(reload_now),
    .reload_vblank(reload_vblank), .vblank(vblank), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .l1_pix(l1_pix), .l2_pix(l2_pix),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb),
    .reload_pending(reload_pending), .reload_done(reload_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int rdiv255(input int q);
    int r;
    r = q % 255;
    return q / 255 + ((r >= 128) ? 1 : 0);
  endfunction

  function automatic logic [23:0] model(input int x, input int y,
                                        input logic [31:0] p1, input logic [31:0] p2);
    int ch [3];
    logic [31:0] px;
    int a, ca;
    for (int c = 0; c < 3; c++) ch[c] = int'(abg[c*8 +: 8]);
    for (int l = 0; l < 2; l++) begin
      px = (l == 0) ? p1 : p2;
      if (!(aw[l][4][0] && x >= int'(aw[l][0][15:0]) && x <= int'(aw[l][0][31:16]) &&
            y >= int'(aw[l][1][15:0]) && y <= int'(aw[l][1][31:16])))
        px = aw[l][2];
      if (aw[l][3][24] && px[23:0] == aw[l][3][23:0]) px = 32'h0;
      ca = int'(aw[l][4][15:8]);
      a = aw[l][4][1] ? rdiv255(int'(px[31:24]) * ca) : ca;
      for (int c = 0; c < 3; c++)
        ch[c] = rdiv255(a * int'(px[c*8 +: 8]) + (255 - a) * ch[c]);
    end
    return {8'(ch[2]), 8'(ch[1]), 8'(ch[0])};
  endfunction

  task automatic wcfg(input int l, input int f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_layer = 1'(l); cfg_field = 3'(f); cfg_wdata = d;
    if (f == 5) sbg = d[23:0];
    else if (f < 5) sw[l][f] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic take_model();
    for (int l = 0; l < 2; l++) for (int f = 0; f < 5; f++) aw[l][f] = sw[l][f];
    abg = sbg;
  endtask

  task automatic reload_imm();
    @(negedge clk);
    reload_now = 1;
    take_model();
    @(negedge clk);
    reload_now = 0;
    check("R8 done pulse", 32'(reload_done), 32'd1);
    @(negedge clk);
    check("R8 done one cycle", 32'(reload_done), 32'd0);
  endtask

  task automatic apply(input int x, input int y, input logic [31:0] p1,
                       input logic [31:0] p2, input string tag, input bit lat_chk);
    @(negedge clk);
    pix_valid = 1; pix_x = CW'(x); pix_y = CW'(y); l1_pix = p1; l2_pix = p2;
    @(negedge clk);
    pix_valid = 0;
    @(negedge clk);
    if (lat_chk) check("R10 not early", 32'(out_valid), 32'd0);
    @(negedge clk);
    check({tag, " rgb"}, 32'(out_rgb), 32'(model(x, y, p1, p2)));
    if (lat_chk) begin
      check("R10 valid", 32'(out_valid), 32'd1);
      check("R10 coords", {24'd0, out_x, out_y}, {24'd0, 4'(x), 4'(y)});
    end
  endtask

  function automatic logic [31:0] gen1(input int x, input int y);
    return {8'(x * 37 + y * 11 + 5), 8'(x * 16 + y), 8'(255 - y * 13), 8'((x * 7) ^ (y * 5))};
  endfunction

  function automatic logic [31:0] gen2(input int x, input int y);
    if ((x + y) % 5 == 0) return {8'(x * 20 + 3), 24'h00FF00};
    if ((x + y) % 5 == 1) return {8'(y * 16 + x), 24'h00FF01};
    return {8'(y * 16 + x), 8'(x * 9), 8'(y * 9 + 1), 8'(x + y)};
  endfunction

  always @(posedge clk) begin
    if (!finished && $time > 64'd750000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 2; l++) for (int f = 0; f < 5; f++) begin
      sw[l][f] = '0; aw[l][f] = '0;
    end
    sbg = '0; abg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 out_valid", 32'(out_valid), 32'd0);
    check("R11 pending", 32'(reload_pending), 32'd0);
    check("R11 done", 32'(reload_done), 32'd0);
    apply(5, 6, 32'hFFFFFFFF, 32'hFFFFFFFF, "R11 black", 1'b1);
    check("R11 black explicit", 32'(out_rgb), 32'd0);

    // Config A: layer 1 windowed, const alpha 0xFF; layer 2 off with alpha 0
    wcfg(0, 0, {16'd9, 16'd2});
    wcfg(0, 1, {16'd12, 16'd3});
    wcfg(0, 2, 32'h80112233);
    wcfg(0, 4, 32'h0000FF01);
    wcfg(1, 2, 32'hFFFFFFFF);
    wcfg(1, 4, 32'h00000000);
    wcfg(1, 5, 32'h00405060);
    reload_imm();
    for (int y = 0; y < SIDE; y++) for (int x = 0; x < SIDE; x++)
      apply(x, y, gen1(x, y), 32'hFFFFFFFF,
            (x >= 2 && x <= 9 && y >= 3 && y <= 12) ? "R1 R5 R6 inside" : "R1 R6 outside",
            (x == 0 && y == 0));

    // Config B: product alpha on both layers, keying on layer 2, full window
    wcfg(0, 4, 32'h00009903);
    wcfg(1, 0, {16'd15, 16'd0});
    wcfg(1, 1, {16'd15, 16'd0});
    wcfg(1, 3, 32'h0100FF00);
    wcfg(1, 4, 32'h0000C003);
    wcfg(0, 7, 32'hDEADBEEF);
    reload_imm();
    for (int y = 0; y < SIDE; y++) for (int x = 0; x < SIDE; x++)
      apply(x, y, gen1(x, y), gen2(x, y),
            ((x + y) % 5 == 0) ? "R3 key hit" : "R4 R5 product", 1'b0);

    // Config C: layer 2 off, opaque black default, const 0xFF -> black
    wcfg(1, 4, 32'h0000FF00);
    wcfg(1, 2, 32'hFF000000);
    wcfg(1, 3, 32'h00000000);
    reload_imm();
    for (int y = 0; y < SIDE; y++) for (int x = 0; x < SIDE; x++)
      apply(x, y, gen1(x, y), gen2(x, y), "R2 R6 black cover", 1'b0);

    // R7 shadow isolation, R9 vblank reload
    wcfg(1, 4, 32'h00000000);
    apply(4, 4, gen1(4, 4), 32'h0, "R7 shadow held", 1'b0);
    check("R7 still black", 32'(out_rgb), 32'd0);
    @(negedge clk);
    reload_vblank = 1;
    @(negedge clk);
    reload_vblank = 0;
    check("R9 pending set", 32'(reload_pending), 32'd1);
    check("R9 no done yet", 32'(reload_done), 32'd0);
    apply(4, 4, gen1(4, 4), 32'h0, "R9 waits for vblank", 1'b0);
    check("R9 still pending", 32'(reload_pending), 32'd1);
    @(negedge clk);
    vblank = 1;
    take_model();
    @(negedge clk);
    vblank = 0;
    check("R9 done pulse", 32'(reload_done), 32'd1);
    check("R9 pending cleared", 32'(reload_pending), 32'd0);
    @(negedge clk);
    check("R9 done one cycle", 32'(reload_done), 32'd0);
    apply(4, 4, gen1(4, 4), 32'h0, "R9 new config", 1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule